// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the processor-facing side of a multi-channel interval timer. It accepts byte-wide writes and reads on a two-bit address. One address is the control port. Each of the others reaches one counter channel. A control word picks a channel and gives it an operating mode, a count type (binary or decimal) and a byte access format. Alternatively, a control word can freeze the channel's running count so that it can be read back.

Each channel keeps its own write and read byte pointers. When the format needs two bytes, the pointers gather the low byte and then the high byte into a 16-bit count. Strobes tell the counting logic when a two-byte load has begun and when a complete count is ready. On the read side, the block picks the right byte from either the live count or the frozen copy. The counting engines are not part of this block: they take the configuration, count and strobes from it and return their live counts to it.

Top module: `tmr_bus_if`

## Requirements
- R1: A write with addr 0 to NCH-1 is a data write to that channel, and addr 3 is the control port. A completed count raises `ready_stb` for the addressed channel only, one cycle after the write. If `wr_en` and `rd_en` are high together, the write is taken and the read is dropped.
- R2: A control word whose bits 7:6 equal 2'b11 changes nothing: no configuration, pointer, latch or strobe.
- R3: Control bits 5:4 give the format: 00 = latch command, 01 = high byte only, 10 = low byte only, 11 = low then high. For a non-latch code, bits 7:6 pick the channel. The next cycle `ch_fmt` takes the code and `cfg_stb` pulses for one cycle.
- R4: Control bits 3:1 give the mode, reported on `ch_mode` as 0 to 5. The codes 000, 001, 100 and 101 map to modes 0, 1, 4 and 5. Codes x10 map to mode 2 and x11 to mode 3.
- R5: Control bit 0 sets `ch_bcd` (0 = 16-bit binary, 1 = four-decade decimal).
- R6: In the low-then-high format, the first data write stores the low byte and pulses `halt_stb`. The second write pulses `ready_stb`, and `count_value` becomes {second, first}.
- R7: In a single-byte format, every data write pulses `ready_stb`, and the byte that was not written is zero in `count_value`.
- R8: A non-latch control word returns that channel's write and read pointers to the low byte.
- R9: A latch command copies `live_count` of the selected channel into a holding register. Reads of that channel return the held bytes in the channel's format order. After the last byte of the held value has been read, reads return live bytes again.
- R10: A latch command to a channel whose held value has not been fully read is ignored.
- R11: A read of addr 3 returns 8'h00.
- R12: In the low-then-high format, reads alternate low and high bytes using a read pointer that data writes do not move.
- R13: After reset, every channel has mode 0, format 11, binary count type, `count_value` 0, both pointers on the low byte, no held value and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle; the read pointer advances at the clock edge |
| addr | input | 2 | Channel 0..NCH-1 or control port 3 |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from addr and state |
| live_count | input | NCH*16 | Running counts returned by the counting engines |
| ch_mode | output | NCH*3 | Normalized mode 0..5 per channel |
| ch_fmt | output | NCH*2 | Access format per channel |
| ch_bcd | output | NCH | Decimal count type per channel |
| cfg_stb | output | NCH | One-cycle pulse after a control word configures the channel |
| count_value | output | NCH*16 | Last fully assembled count per channel |
| halt_stb | output | NCH | One-cycle pulse after the first byte of a two-byte load |
| ready_stb | output | NCH | One-cycle pulse after a count is complete |

## Verification
Some properties are checked on every cycle: an illegal control word leaves every output stable, a reported mode never exceeds 5, a read of the control port returns zero, and strobes appear only after a data write in a format that allows them. Other behaviour depends on history, and only the bench scenarios can show it. This covers the ordering of the write and read pointers, the read pointer staying independent of data writes, pointer reset on reconfiguration, and the lifetime of a latched value. It also covers a second latch being ignored while the first is still being read. The bench checks these against a behavioural model on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 16;
    localparam logic [1:0] CTRL_ADDR = 2'b11;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_HI    = 2'b01,
        FMT_LO    = 2'b10,
        FMT_LOHI  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [1:0] sel;
        fmt_e       fmt;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_t;

    // Fold the don't-care upper bit of the periodic modes.
    function automatic logic [2:0] norm_mode(input logic [2:0] code);
        if (code[1])
            return {1'b0, code[1:0]};
        return code;
    endfunction

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output ctrl_t             ctrl,
    output logic              legal
);
    always_comb begin
        ctrl.sel  = byte_in[7:6];
        ctrl.fmt  = fmt_e'(byte_in[5:4]);
        ctrl.mode = norm_mode(byte_in[3:1]);
        ctrl.bcd  = byte_in[0];
        legal     = (byte_in[7:6] != 2'b11);
    end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               latch_cmd,
    input  ctrl_t              ctrl,
    input  logic               data_wr,
    input  logic               data_rd,
    input  logic [BYTE_W-1:0]  wbyte,
    input  logic [COUNT_W-1:0] live,
    output logic [2:0]         mode,
    output fmt_e               fmt,
    output logic               bcd,
    output logic               cfg_stb,
    output logic [COUNT_W-1:0] count,
    output logic               halt_stb,
    output logic               ready_stb,
    output logic [BYTE_W-1:0]  rd_byte
);
    logic               wptr;
    logic               rptr;
    logic               held;
    logic [COUNT_W-1:0] hold;
    logic [BYTE_W-1:0]  lo_keep;
    logic [COUNT_W-1:0] src;
    logic               last_rd;

    assign last_rd = (fmt != FMT_LOHI) || rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= 3'd0;
            fmt       <= FMT_LOHI;
            bcd       <= 1'b0;
            cfg_stb   <= 1'b0;
            count     <= '0;
            halt_stb  <= 1'b0;
            ready_stb <= 1'b0;
            wptr      <= 1'b0;
            rptr      <= 1'b0;
            held      <= 1'b0;
            hold      <= '0;
            lo_keep   <= '0;
        end else begin
            cfg_stb   <= 1'b0;
            halt_stb  <= 1'b0;
            ready_stb <= 1'b0;
            if (cfg_wr) begin
                mode    <= ctrl.mode;
                fmt     <= ctrl.fmt;
                bcd     <= ctrl.bcd;
                cfg_stb <= 1'b1;
                wptr    <= 1'b0;
                rptr    <= 1'b0;
                held    <= 1'b0;
            end else begin
                if (latch_cmd && !held) begin
                    hold <= live;
                    held <= 1'b1;
                end
                if (data_wr) begin
                    unique case (fmt)
                        FMT_HI: begin
                            count     <= {wbyte, {BYTE_W{1'b0}}};
                            ready_stb <= 1'b1;
                        end
                        FMT_LO: begin
                            count     <= {{BYTE_W{1'b0}}, wbyte};
                            ready_stb <= 1'b1;
                        end
                        FMT_LOHI: begin
                            if (!wptr) begin
                                lo_keep  <= wbyte;
                                halt_stb <= 1'b1;
                                wptr     <= 1'b1;
                            end else begin
                                count     <= {wbyte, lo_keep};
                                ready_stb <= 1'b1;
                                wptr      <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                if (data_rd) begin
                    if (fmt == FMT_LOHI)
                        rptr <= ~rptr;
                    if (held && last_rd)
                        held <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        src = held ? hold : live;
        unique case (fmt)
            FMT_HI:   rd_byte = src[COUNT_W-1:BYTE_W];
            FMT_LOHI: rd_byte = rptr ? src[COUNT_W-1:BYTE_W] : src[BYTE_W-1:0];
            default:  rd_byte = src[BYTE_W-1:0];
        endcase
    end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [1:0]            addr,
    input  logic [NCH*BYTE_W-1:0] bytes,
    output logic [BYTE_W-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == 2'(i))
                rdata = bytes[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [1:0]             addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic [NCH*16-1:0]      live_count,
    output logic [NCH*3-1:0]       ch_mode,
    output logic [NCH*2-1:0]       ch_fmt,
    output logic [NCH-1:0]         ch_bcd,
    output logic [NCH-1:0]         cfg_stb,
    output logic [NCH*16-1:0]      count_value,
    output logic [NCH-1:0]         halt_stb,
    output logic [NCH-1:0]         ready_stb
);
    ctrl_t                 ctrl;
    logic                  legal;
    logic                  ctrl_wr;
    logic [NCH*BYTE_W-1:0] rd_bytes;

    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

    tmr_ctrl_decode u_dec (
        .byte_in (wdata),
        .ctrl    (ctrl),
        .legal   (legal)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic picked;
        fmt_e fmt_q;
        assign picked = ctrl_wr && legal && (ctrl.sel == 2'(g));
        assign ch_fmt[g*2 +: 2] = fmt_q;

        tmr_chan_port u_ch (
            .clk       (clk),
            .rst       (rst),
            .cfg_wr    (picked && (ctrl.fmt != FMT_LATCH)),
            .latch_cmd (picked && (ctrl.fmt == FMT_LATCH)),
            .ctrl      (ctrl),
            .data_wr   (wr_en && (addr == 2'(g))),
            .data_rd   (rd_en && !wr_en && (addr == 2'(g))),
            .wbyte     (wdata),
            .live      (live_count[g*COUNT_W +: COUNT_W]),
            .mode      (ch_mode[g*3 +: 3]),
            .fmt       (fmt_q),
            .bcd       (ch_bcd[g]),
            .cfg_stb   (cfg_stb[g]),
            .count     (count_value[g*COUNT_W +: COUNT_W]),
            .halt_stb  (halt_stb[g]),
            .ready_stb (ready_stb[g]),
            .rd_byte   (rd_bytes[g*BYTE_W +: BYTE_W])
        );
    end

    tmr_read_mux #(.NCH(NCH)) u_rmux (
        .addr  (addr),
        .bytes (rd_bytes),
        .rdata (rdata)
    );
endmodule

// File: rtl/tmr_bus_if_chk.sv
module tmr_bus_if_chk #(
    parameter int NCH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [NCH*3-1:0]  ch_mode,
    input logic [NCH*2-1:0]  ch_fmt,
    input logic [NCH-1:0]    ch_bcd,
    input logic [NCH-1:0]    cfg_stb,
    input logic [NCH*16-1:0] count_value,
    input logic [NCH-1:0]    halt_stb,
    input logic [NCH-1:0]    ready_stb
);
    // R11
    a_r11_ctrl_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == 2'b11) |-> (rdata == 8'h00));

    // R2
    a_r2_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'b11 && wdata[7:6] == 2'b11) |=>
        ($stable(ch_mode) && $stable(ch_fmt) && $stable(ch_bcd) && cfg_stb == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_c
        // R4
        a_r4_mode_legal: assert property (@(posedge clk) disable iff (rst)
            ch_mode[g*3 +: 3] <= 3'd5);

        // R1
        a_r1_ready_after_write: assert property (@(posedge clk) disable iff (rst)
            ready_stb[g] |-> $past(wr_en && addr == 2'(g)));

        // R6
        a_r6_halt_only_lohi: assert property (@(posedge clk) disable iff (rst)
            halt_stb[g] |-> (ch_fmt[g*2 +: 2] == 2'b11 && !ready_stb[g]));

        // R7
        a_r7_single_zero_hi: assert property (@(posedge clk) disable iff (rst)
            (ready_stb[g] && ch_fmt[g*2 +: 2] == 2'b10) |-> (count_value[g*16+8 +: 8] == 8'h00));
    end
endmodule

bind tmr_bus_if tmr_bus_if_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .ch_mode     (ch_mode),
    .ch_fmt      (ch_fmt),
    .ch_bcd      (ch_bcd),
    .cfg_stb     (cfg_stb),
    .count_value (count_value),
    .halt_stb    (halt_stb),
    .ready_stb   (ready_stb)
);

// File: tb/tmr_bus_if_test.sv
`timescale 1ns/1ps
module tmr_bus_if_test;
    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en, rd_en;
    logic [1:0]      addr;
    logic [7:0]      wdata;
    logic [7:0]      rdata;
    logic [NCH*16-1:0] live_count;
    logic [NCH*3-1:0]  ch_mode;
    logic [NCH*2-1:0]  ch_fmt;
    logic [NCH-1:0]    ch_bcd, cfg_stb, halt_stb, ready_stb;
    logic [NCH*16-1:0] count_value;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    tmr_bus_if #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_count(live_count),
        .ch_mode(ch_mode), .ch_fmt(ch_fmt), .ch_bcd(ch_bcd), .cfg_stb(cfg_stb),
        .count_value(count_value), .halt_stb(halt_stb), .ready_stb(ready_stb)
    );

    // Behavioural reference model
    int m_mode[NCH], m_fmt[NCH], m_bcd[NCH], m_cnt[NCH];
    int m_wp[NCH], m_rp[NCH], m_held[NCH], m_hold[NCH], m_lo[NCH];
    bit m_cfg[NCH], m_halt[NCH], m_rdy[NCH];

    function automatic int live_of(int c);
        return int'(live_count[c*16 +: 16]);
    endfunction

    function automatic int exp_rdata();
        int c, s;
        if (addr == 2'b11) return 0;               // R11
        c = int'(addr);
        s = m_held[c] ? m_hold[c] : live_of(c);   // R9
        if (m_fmt[c] == 1) return (s >> 8) & 255;
        if (m_fmt[c] == 3 && m_rp[c] == 1) return (s >> 8) & 255;  // R12
        return s & 255;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_mode[c] = 0; m_fmt[c] = 3; m_bcd[c] = 0; m_cnt[c] = 0;
                m_wp[c] = 0; m_rp[c] = 0; m_held[c] = 0; m_hold[c] = 0; m_lo[c] = 0;
                m_cfg[c] = 0; m_halt[c] = 0; m_rdy[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                m_cfg[c] = 0; m_halt[c] = 0; m_rdy[c] = 0;
            end
            if (wr_en && addr == 2'b11) begin
                int sel, f, md;
                sel = int'(wdata[7:6]);
                f   = int'(wdata[5:4]);
                md  = int'(wdata[3:1]);
                if (md == 2 || md == 6) md = 2;
                if (md == 3 || md == 7) md = 3;
                if (sel != 3) begin
                    if (f == 0) begin
                        if (!m_held[sel]) begin
                            m_held[sel] = 1; m_hold[sel] = live_of(sel);
                        end
                    end else begin
                        m_mode[sel] = md; m_fmt[sel] = f; m_bcd[sel] = int'(wdata[0]);
                        m_cfg[sel] = 1; m_wp[sel] = 0; m_rp[sel] = 0; m_held[sel] = 0;
                    end
                end
            end else if (wr_en) begin
                int c;
                c = int'(addr);
                if (m_fmt[c] == 1) begin m_cnt[c] = int'(wdata) << 8; m_rdy[c] = 1; end
                else if (m_fmt[c] == 2) begin m_cnt[c] = int'(wdata); m_rdy[c] = 1; end
                else if (m_wp[c] == 0) begin m_lo[c] = int'(wdata); m_halt[c] = 1; m_wp[c] = 1; end
                else begin m_cnt[c] = (int'(wdata) << 8) | m_lo[c]; m_rdy[c] = 1; m_wp[c] = 0; end
            end else if (rd_en && addr != 2'b11) begin
                int c;
                bit last;
                c = int'(addr);
                last = (m_fmt[c] != 3) || (m_rp[c] == 1);
                if (m_fmt[c] == 3) m_rp[c] = 1 - m_rp[c];
                if (m_held[c] && last) m_held[c] = 0;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                chk("R4", "ch_mode", int'(ch_mode[c*3 +: 3]), m_mode[c]);
                chk("R3", "ch_fmt", int'(ch_fmt[c*2 +: 2]), m_fmt[c]);
                chk("R5", "ch_bcd", int'(ch_bcd[c]), m_bcd[c]);
                chk("R3", "cfg_stb", int'(cfg_stb[c]), int'(m_cfg[c]));
                chk("R6", "count_value", int'(count_value[c*16 +: 16]), m_cnt[c]);
                chk("R6", "halt_stb", int'(halt_stb[c]), int'(m_halt[c]));
                chk("R1", "ready_stb", int'(ready_stb[c]), int'(m_rdy[c]));
            end
            if (rd_en) chk("R9", "rdata", int'(rdata), exp_rdata());
        end
    end

    task automatic idle();
        @(negedge clk); #1;
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1; rd_en = 0; addr = a; wdata = d;
    endtask

    task automatic rd(logic [1:0] a);
        @(negedge clk); #1;
        wr_en = 0; rd_en = 1; addr = a;
    endtask

    // Read and compare with an explicit expected byte
    task automatic rd_expect(string req, logic [1:0] a, int exp);
        rd(a);
        #1 chk(req, "read byte", int'(rdata), exp);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                while (cycles < 20000) begin @(posedge clk); cycles++; end
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        live_count = {16'h3333, 16'h2222, 16'h1111};
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        // R13 reset state
        chk("R13", "fmt after reset", int'(ch_fmt), 6'b111111);
        chk("R13", "mode after reset", int'(ch_mode), 0);
        chk("R13", "count after reset", int'(count_value), 0);

        // R3 R4 R5 R7: ch0 low-only, mode code 110 -> 2, decimal
        wr(2'b11, 8'b00_10_110_1);
        idle();
        chk("R4", "mode code 110", int'(ch_mode[2:0]), 2);
        chk("R5", "bcd bit", int'(ch_bcd[0]), 1);
        wr(2'b00, 8'h5A);
        idle();
        chk("R7", "low-only count", int'(count_value[15:0]), 16'h005A);

        // ch1 high-only, mode code 111 -> 3
        wr(2'b11, 8'b01_01_111_0);
        wr(2'b01, 8'h12);
        idle();
        chk("R7", "high-only count", int'(count_value[31:16]), 16'h1200);
        chk("R4", "mode code 111", int'(ch_mode[5:3]), 3);

        // ch2 low-then-high, mode 4, then mode 5 on ch0
        wr(2'b11, 8'b10_11_100_0);
        wr(2'b10, 8'h34);
        idle();
        chk("R6", "halt after first byte", int'(halt_stb[2]), 1);
        wr(2'b10, 8'hAB);
        idle();
        chk("R6", "two-byte count", int'(count_value[47:32]), 16'hAB34);
        wr(2'b11, 8'b00_10_101_0);
        idle();
        chk("R4", "mode code 101", int'(ch_mode[2:0]), 5);

        // R2 illegal select
        wr(2'b11, 8'b11_01_001_1);
        idle();
        chk("R2", "illegal select fmt", int'(ch_fmt), 6'b11_01_10);

        // R11 control read
        rd_expect("R11", 2'b11, 0);

        // R12 read alternation on ch2, independent of writes
        live_count[47:32] = 16'hC0DE;
        rd_expect("R12", 2'b10, 8'hDE);
        wr(2'b10, 8'h01);          // write pointer moves, read pointer does not
        rd_expect("R12", 2'b10, 8'hC0);
        rd_expect("R12", 2'b10, 8'hDE);

        // R8: reconfigure resets both pointers mid-sequence
        wr(2'b11, 8'b10_11_000_0);
        wr(2'b10, 8'h77);
        wr(2'b10, 8'h66);
        idle();
        chk("R8", "count after pointer reset", int'(count_value[47:32]), 16'h6677);
        rd_expect("R8", 2'b10, 8'hDE);

        // R9 R10: latch ch2 (read pointer now on high byte)
        wr(2'b11, 8'b10_11_000_0);    // reset pointers
        wr(2'b11, 8'b10_00_000_0);    // latch C0DE
        idle();
        live_count[47:32] = 16'h1357;
        wr(2'b11, 8'b10_00_000_0);    // ignored, still held
        idle();
        live_count[47:32] = 16'h2468;
        rd_expect("R9", 2'b10, 8'hDE);
        rd_expect("R10", 2'b10, 8'hC0);
        rd_expect("R9", 2'b10, 8'h68); // released, live again

        // latch on single-byte ch1, released after one read
        live_count[31:16] = 16'h4455;
        wr(2'b11, 8'b01_00_000_0);
        idle();
        live_count[31:16] = 16'h9900;
        rd_expect("R9", 2'b01, 8'h44);
        rd_expect("R9", 2'b01, 8'h99);

        // R1 write and read together: write wins
        @(negedge clk); #1;
        wr_en = 1; rd_en = 1; addr = 2'b00; wdata = 8'h3C;
        idle();
        chk("R1", "write priority", int'(count_value[15:0]), 16'h003C);

        repeat (3) idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule